// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This block is a small coprocessor on a CPU register bus. Software selects an operand width in a control word, writes a numerator and then a denominator, and reads back a 64-bit signed quotient and a 64-bit signed remainder. Each 64-bit quantity is reached as two 32-bit words, with the low word at the lower address.

A write to either denominator word starts an operation. From the next cycle the control word reports busy, the error flag reflects a zero divisor, and both result registers read as zero. The result becomes visible after a fixed, mode-dependent number of cycles. A restoring shift-subtract engine performs the work on operand magnitudes. A countdown timer, separate from the engine, sets the moment the result is published, so the latency seen by software does not depend on the data.

Top module: `sdiv_mmio`

## Requirements
- R1: Word addresses are: control 0, numerator 4 (low) and 5 (high), denominator 6 (low) and 7 (high), quotient 8 (low) and 9 (high), remainder 10 (low) and 11 (high). Control bits [1:0] hold a read/write mode field, bit 14 is the zero-divisor flag, bit 15 is busy, and all other bits read 0.
- R2: Mode 0 divides a 32-bit numerator by a 32-bit denominator, mode 1 divides 64 bits by 32 bits, and mode 2 divides 64 bits by 64 bits. Any operand used at 32 bits is the low word, sign-extended from bit 31, and its high word has no effect.
- R3: Mode 3 gives the same results and the same latency as mode 1.
- R4: Writing either denominator word starts a division. On the next cycle busy reads 1, bit 14 shows the new zero-divisor state, and all four result words read 0.
- R5: Busy falls, and the results appear, 36 clock edges after the starting write edge in mode 0 and 68 edges after it in the other modes. Busy is still 1 one edge earlier.
- R6: The quotient truncates toward zero and the remainder has the sign of the numerator, in 64-bit two's complement. Dividing -2^63 by -1 gives a quotient of -2^63 and a remainder of 0.
- R7: If the sign-extended 64-bit denominator is zero, bit 14 is set. The quotient is then -1 for a numerator of 0 or more and +1 for a negative numerator, and the remainder equals the sign-extended numerator.
- R8: A start while busy abandons the running operation and uses the new operands. The latency is counted from the latest start.
- R9: Writes to the control, numerator, quotient or remainder addresses start nothing, and they leave the result registers unchanged.
- R10: After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Counting from the edge that samples the starting denominator write, the busy flag, the cleared results and the zero-divisor flag are due after one edge. The results and the falling busy flag are due after 36 edges in mode 0 and after 68 in the other modes. Each scenario task writes on the falling edge, probes just after the first rising edge, probes again one edge before the deadline to confirm busy is still set, and then probes just after the deadline edge. A stray early or late update therefore fails one of the probes. The restart case counts from the second start only, and expected results come from a signed reference model that applies the mode's sign extension.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;

   typedef enum logic [1:0] {
      MODE_W32    = 2'd0,
      MODE_N64D32 = 2'd1,
      MODE_W64    = 2'd2,
      MODE_ALIAS  = 2'd3
   } div_mode_e;

   localparam int unsigned A_CTRL   = 0;
   localparam int unsigned A_NUM_LO = 4;
   localparam int unsigned A_NUM_HI = 5;
   localparam int unsigned A_DEN_LO = 6;
   localparam int unsigned A_DEN_HI = 7;
   localparam int unsigned A_QUO_LO = 8;
   localparam int unsigned A_QUO_HI = 9;
   localparam int unsigned A_REM_LO = 10;
   localparam int unsigned A_REM_HI = 11;

   localparam int unsigned CTRL_DZ_BIT   = 14;
   localparam int unsigned CTRL_BUSY_BIT = 15;

   function automatic logic mode_narrow_num(div_mode_e m);
      return m == MODE_W32;
   endfunction

   function automatic logic mode_narrow_den(div_mode_e m);
      return m != MODE_W64;
   endfunction

endpackage

// File: rtl/sdiv_timer.sv
`timescale 1ns/1ps
module sdiv_timer #(
   parameter int unsigned LAT_NARROW = 36,
   parameter int unsigned LAT_WIDE   = 68
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic narrow,
   output logic busy,
   output logic fire
);
   localparam int unsigned CNT_W = $clog2(LAT_WIDE + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= narrow ? CNT_W'(LAT_NARROW) : CNT_W'(LAT_WIDE);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign busy = (cnt_q != '0);
   assign fire = (cnt_q == CNT_W'(1));

   // R5: the countdown never exceeds the longest latency
   a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= CNT_W'(LAT_WIDE)));

endmodule

// File: rtl/sdiv_core.sv
`timescale 1ns/1ps
module sdiv_core #(
   parameter int unsigned DW           = 64,
   parameter int unsigned NARROW_ITERS = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          narrow,
   input  logic [DW-1:0] num_mag,
   input  logic [DW-1:0] den_mag,
   output logic [DW-1:0] q_mag,
   output logic [DW-1:0] r_mag,
   output logic          active
);
   localparam int unsigned ITER_W = $clog2(DW + 1);

   logic [DW-1:0]     rem_r, dvd_r, quo_r, den_r;
   logic [ITER_W-1:0] cnt_r;
   logic [DW:0]       trial;
   logic              ge;

   assign trial = {rem_r, dvd_r[DW-1]};
   assign ge    = (trial >= {1'b0, den_r});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_r <= '0;
         dvd_r <= '0;
         quo_r <= '0;
         den_r <= '0;
         cnt_r <= '0;
      end else if (start) begin
         rem_r <= '0;
         quo_r <= '0;
         den_r <= den_mag;
         dvd_r <= narrow ? (num_mag << NARROW_ITERS) : num_mag;
         cnt_r <= narrow ? ITER_W'(NARROW_ITERS) : ITER_W'(DW);
      end else if (cnt_r != '0) begin
         rem_r <= DW'(ge ? (trial - {1'b0, den_r}) : trial);
         dvd_r <= dvd_r << 1;
         quo_r <= {quo_r[DW-2:0], ge};
         cnt_r <= cnt_r - ITER_W'(1);
      end
   end

   assign q_mag  = quo_r;
   assign r_mag  = rem_r;
   assign active = (cnt_r != '0);

   // R6: a finished magnitude remainder is below the divisor
   a_r6_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(active) && den_r != '0) |-> (rem_r < den_r));

endmodule

// File: rtl/sdiv_mmio.sv
`timescale 1ns/1ps
module sdiv_mmio
   import sdiv_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned LAT_NARROW = 36,
   parameter int unsigned LAT_WIDE   = 68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata
);
   localparam int unsigned DW = 2 * WORD_W;

   generate
      if (WORD_W < 16) begin : g_chk_word
         $error("sdiv_mmio: WORD_W must hold the control flags");
      end
      if (ADDR_W < 4) begin : g_chk_addr
         $error("sdiv_mmio: ADDR_W too small for the register map");
      end
      if (LAT_NARROW <= WORD_W) begin : g_chk_narrow
         $error("sdiv_mmio: LAT_NARROW must exceed the narrow iteration count");
      end
      if (LAT_WIDE <= DW || LAT_WIDE < LAT_NARROW) begin : g_chk_wide
         $error("sdiv_mmio: LAT_WIDE must exceed the wide iteration count");
      end
   endgenerate

   logic [1:0]    mode_q;
   logic [DW-1:0] num_q, den_q, den_now;
   logic [DW-1:0] quo_q, rem_q, num_ext_q;
   logic          dz_q, qneg_q, rneg_q;

   logic          wr_ctrl, wr_num_lo, wr_num_hi, wr_den_lo, wr_den_hi, start;
   div_mode_e     cur_mode;
   logic          narrow_num, narrow_den;
   logic [DW-1:0] num_ext, den_ext, num_mag, den_mag;
   logic          num_neg, den_neg;
   logic          busy, fire, core_active;
   logic [DW-1:0] core_q, core_r;

   assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
   assign wr_num_lo = bus_wr && (bus_addr == ADDR_W'(A_NUM_LO));
   assign wr_num_hi = bus_wr && (bus_addr == ADDR_W'(A_NUM_HI));
   assign wr_den_lo = bus_wr && (bus_addr == ADDR_W'(A_DEN_LO));
   assign wr_den_hi = bus_wr && (bus_addr == ADDR_W'(A_DEN_HI));
   assign start     = wr_den_lo || wr_den_hi;

   // Denominator as it stands after the current write, so a start sees it
   always_comb begin
      den_now = den_q;
      if (wr_den_lo) den_now[WORD_W-1:0]  = bus_wdata;
      if (wr_den_hi) den_now[DW-1:WORD_W] = bus_wdata;
   end

   assign cur_mode   = div_mode_e'(mode_q);
   assign narrow_num = mode_narrow_num(cur_mode);
   assign narrow_den = mode_narrow_den(cur_mode);

   assign num_ext = narrow_num ? {{WORD_W{num_q[WORD_W-1]}}, num_q[WORD_W-1:0]} : num_q;
   assign den_ext = narrow_den ? {{WORD_W{den_now[WORD_W-1]}}, den_now[WORD_W-1:0]} : den_now;
   assign num_neg = num_ext[DW-1];
   assign den_neg = den_ext[DW-1];
   assign num_mag = num_neg ? -num_ext : num_ext;
   assign den_mag = den_neg ? -den_ext : den_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         num_q  <= '0;
         den_q  <= '0;
      end else begin
         if (wr_ctrl)   mode_q              <= bus_wdata[1:0];
         if (wr_num_lo) num_q[WORD_W-1:0]  <= bus_wdata;
         if (wr_num_hi) num_q[DW-1:WORD_W] <= bus_wdata;
         if (start)     den_q              <= den_now;
      end
   end

   sdiv_timer #(
      .LAT_NARROW (LAT_NARROW),
      .LAT_WIDE   (LAT_WIDE)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .narrow (narrow_num),
      .busy   (busy),
      .fire   (fire)
   );

   sdiv_core #(
      .DW           (DW),
      .NARROW_ITERS (WORD_W)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .narrow  (narrow_num),
      .num_mag (num_mag),
      .den_mag (den_mag),
      .q_mag   (core_q),
      .r_mag   (core_r),
      .active  (core_active)
   );

   // Results: cleared on start, published when the timer fires
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q     <= '0;
         rem_q     <= '0;
         num_ext_q <= '0;
         dz_q      <= 1'b0;
         qneg_q    <= 1'b0;
         rneg_q    <= 1'b0;
      end else if (start) begin
         quo_q     <= '0;
         rem_q     <= '0;
         num_ext_q <= num_ext;
         dz_q      <= (den_ext == '0);
         qneg_q    <= num_neg ^ den_neg;
         rneg_q    <= num_neg;
      end else if (fire) begin
         if (dz_q) begin
            quo_q <= rneg_q ? DW'(1) : '1;
            rem_q <= num_ext_q;
         end else begin
            quo_q <= qneg_q ? -core_q : core_q;
            rem_q <= rneg_q ? -core_r : core_r;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(A_CTRL): begin
            bus_rdata[1:0]           = mode_q;
            bus_rdata[CTRL_DZ_BIT]   = dz_q;
            bus_rdata[CTRL_BUSY_BIT] = busy;
         end
         ADDR_W'(A_NUM_LO): bus_rdata = num_q[WORD_W-1:0];
         ADDR_W'(A_NUM_HI): bus_rdata = num_q[DW-1:WORD_W];
         ADDR_W'(A_DEN_LO): bus_rdata = den_q[WORD_W-1:0];
         ADDR_W'(A_DEN_HI): bus_rdata = den_q[DW-1:WORD_W];
         ADDR_W'(A_QUO_LO): bus_rdata = quo_q[WORD_W-1:0];
         ADDR_W'(A_QUO_HI): bus_rdata = quo_q[DW-1:WORD_W];
         ADDR_W'(A_REM_LO): bus_rdata = rem_q[WORD_W-1:0];
         ADDR_W'(A_REM_HI): bus_rdata = rem_q[DW-1:WORD_W];
         default:           bus_rdata = '0;
      endcase
   end

   // R4: a start raises busy and clears both results on the next cycle
   a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && quo_q == '0 && rem_q == '0));

   // R5: the engine has finished before the timer publishes
   a_r5_core_done: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !core_active);

   // R7: zero-divisor completion value
   a_r7_dz_result: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && dz_q) |-> (rem_q == num_ext_q && (quo_q == DW'(1) || quo_q == '1)));

   // R9: results do not move while idle without a start
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(quo_q) && $stable(rem_q)));

endmodule

// File: tb/tb_sdiv_mmio.sv
`timescale 1ns/1ps
module tb_sdiv_mmio;

   localparam int A_CTRL = 0, A_NUM_LO = 4, A_NUM_HI = 5, A_DEN_LO = 6, A_DEN_HI = 7;
   localparam int A_QUO_LO = 8, A_QUO_HI = 9, A_REM_LO = 10, A_REM_HI = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sdiv_mmio dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      bus_addr = 4'(a);
      #1;
      v = bus_rdata;
   endtask

   task automatic rd64(input int a, output logic [63:0] v);
      logic [31:0] lo, hi;
      rd(a, lo);
      rd(a + 1, hi);
      v = {hi, lo};
   endtask

   // Reference model from R2, R3, R6, R7
   task automatic model(input logic [1:0] mode, input logic [63:0] nreg, input logic [63:0] dreg,
                        output logic [63:0] q, output logic [63:0] r, output logic dz);
      longint n, d;
      n = (mode == 2'd0) ? {{32{nreg[31]}}, nreg[31:0]} : nreg;
      d = (mode == 2'd2) ? dreg : {{32{dreg[31]}}, dreg[31:0]};
      dz = (d == 0);
      if (dz) begin
         q = (n < 0) ? 64'd1 : {64{1'b1}};
         r = n;
      end else if (n == 64'h8000_0000_0000_0000 && d == -1) begin
         q = n;
         r = 64'd0;
      end else begin
         q = n / d;
         r = n % d;
      end
   endtask

   task automatic run_div(input string req, input logic [1:0] mode, input logic [63:0] n, input logic [63:0] d);
      logic [63:0] eq, er, v;
      logic        edz;
      logic [31:0] c;
      int          lat;
      model(mode, n, d, eq, er, edz);
      lat = (mode == 2'd0) ? 36 : 68;
      wr(A_CTRL, {30'd0, mode});
      wr(A_NUM_LO, n[31:0]);
      wr(A_NUM_HI, n[63:32]);
      wr(A_DEN_LO, d[31:0]);
      wr(A_DEN_HI, d[63:32]);
      // R4: one edge after the start
      rd(A_CTRL, c);
      chk("R4", "ctrl after start", {32'd0, c}, 64'h8000 | (64'(edz) << 14) | 64'(mode));
      rd64(A_QUO_LO, v);
      chk("R4", "quotient cleared", v, 64'd0);
      // R5: busy still set one edge before the deadline
      repeat (lat - 1) @(posedge clk);
      #1;
      rd(A_CTRL, c);
      chk("R5", "busy before deadline", {63'd0, c[15]}, 64'd1);
      @(posedge clk);
      #1;
      rd(A_CTRL, c);
      chk("R5", "busy at deadline", {63'd0, c[15]}, 64'd0);
      chk("R7", "zero-divisor flag", {63'd0, c[14]}, {63'd0, edz});
      rd64(A_QUO_LO, v);
      chk(req, "quotient", v, eq);
      rd64(A_REM_LO, v);
      chk(req, "remainder", v, er);
   endtask

   task automatic t_reset();
      logic [31:0] c;
      logic [63:0] v;
      rd(A_CTRL, c);
      chk("R10", "ctrl after reset", {32'd0, c}, 64'd0);
      rd64(A_NUM_LO, v);
      chk("R10", "numerator after reset", v, 64'd0);
      rd64(A_QUO_LO, v);
      chk("R10", "quotient after reset", v, 64'd0);
      rd64(A_REM_LO, v);
      chk("R10", "remainder after reset", v, 64'd0);
   endtask

   task automatic t_modes();
      run_div("R6", 2'd0, 64'd1000, 64'd7);                                   // R2 mode 0
      run_div("R2", 2'd0, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007);  // high words ignored
      run_div("R2", 2'd1, 64'h0000_0123_4567_89AB, 64'hABCD_0000_FFFF_FFF0);  // 64/32
      run_div("R6", 2'd2, 64'hF000_0000_1234_5678, 64'h0000_0001_0000_0003);  // 64/64
      run_div("R3", 2'd3, 64'h0000_0123_4567_89AB, 64'hABCD_0000_FFFF_FFF0);  // alias of mode 1
      run_div("R6", 2'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);  // overflow wrap
      run_div("R6", 2'd0, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0002);  // -7/2
   endtask

   task automatic t_zero_div();
      run_div("R7", 2'd2, 64'd12345, 64'd0);
      run_div("R7", 2'd0, 64'h5555_5555_FFFF_FFFB, 64'h0000_ABCD_0000_0000);
      // R4: the next start clears bit 14 (checked inside run_div)
      run_div("R4", 2'd1, 64'd99, 64'd10);
   endtask

   task automatic t_restart();
      logic [63:0] eq, er, v;
      logic        edz;
      logic [31:0] c;
      model(2'd2, 64'd5000, 64'd9, eq, er, edz);
      wr(A_CTRL, 32'd2);
      wr(A_NUM_LO, 32'd5000);
      wr(A_NUM_HI, 32'd0);
      wr(A_DEN_LO, 32'd3);
      repeat (10) @(posedge clk);
      wr(A_DEN_LO, 32'd9);   // R8: restart with new divisor
      repeat (67) @(posedge clk);
      #1;
      rd(A_CTRL, c);
      chk("R8", "busy before restarted deadline", {63'd0, c[15]}, 64'd1);
      @(posedge clk);
      #1;
      rd(A_CTRL, c);
      chk("R8", "busy after restarted deadline", {63'd0, c[15]}, 64'd0);
      rd64(A_QUO_LO, v);
      chk("R8", "restarted quotient", v, eq);
      rd64(A_REM_LO, v);
      chk("R8", "restarted remainder", v, er);
   endtask

   task automatic t_no_start();
      logic [63:0] q0, r0, v;
      logic [31:0] c;
      run_div("R6", 2'd1, 64'hFFFF_FFFF_FFFF_FC18, 64'd30);
      rd64(A_QUO_LO, q0);
      rd64(A_REM_LO, r0);
      wr(A_CTRL, 32'd2);
      wr(A_NUM_LO, 32'h1111_2222);
      wr(A_NUM_HI, 32'h3333_4444);
      wr(A_QUO_LO, 32'hAAAA_AAAA);
      wr(A_REM_HI, 32'h5555_5555);
      rd(A_CTRL, c);
      chk("R9", "no busy after other writes", {32'd0, c}, 64'd2);
      rd64(A_QUO_LO, v);
      chk("R9", "quotient unchanged", v, q0);
      rd64(A_REM_LO, v);
      chk("R9", "remainder unchanged", v, r0);
      rd64(A_NUM_LO, v);
      chk("R1", "numerator readback", v, 64'h3333_4444_1111_2222);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_zero_div();
      t_restart();
      t_no_start();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule